// File: doc/BRIEF.md
# Prioritized Multi-Channel DMA Selector

This block lets several peripherals share one DMA transfer engine. Every channel owns a request input, an acknowledge output, a memory address register and a remaining-word counter. The CPU loads the address, count and an enable flag through a simple write port. When the CPU has granted the buses, a fixed-priority arbiter picks the lowest-numbered channel that is enabled, has words left and is requesting. The arbiter latches that channel and presents its address to the shared bus sequencer as one word transfer. The transfer travels on a valid/ready pair. Once the sequencer accepts the word, only the winning channel's address steps up and its count steps down.

Arbitration runs again after every word, so a more urgent peripheral can cut into the block of a less urgent one between two words. The interrupted channel picks up later at its saved address. A channel whose count reaches zero sets its done flag and drops out of arbitration until the CPU writes it again. There is always at least one idle cycle between two words.

Back-pressure rules on the word interface: the selector raises `xfer_valid` in the cycle after it wins arbitration. It then holds `xfer_valid`, `xfer_addr` and `xfer_chan` unchanged until the sequencer returns `xfer_ready`. The word completes on the first clock edge where both signals are high. `xfer_valid` is low in the cycle after that edge.

Top module: `dma_chan_select`

## Requirements
- R1: After reset, `dack`, `done`, `xfer_valid` and `bus_req` are all zero, and every channel is disabled with a count of zero.
- R2: `bus_req` is high exactly when some channel is enabled, has a nonzero count and has its `dreq` bit high, or when a word is outstanding (`xfer_valid` high).
- R3: A word starts only from an idle cycle in which `bus_gnt` is high and some channel is eligible. `xfer_valid` rises one cycle later. It falls in the cycle after the edge where `xfer_valid` and `xfer_ready` are both high.
- R4: Priority is fixed: among eligible channels, the lowest index wins (channel 0 is the most urgent).
- R5: Only the winning channel's `dack` bit is high while its word is outstanding. `dack` is zero when `xfer_valid` is low, so at most one bit is ever set.
- R6: While `xfer_valid` is high and `xfer_ready` is low, `xfer_addr` and `xfer_chan` hold their values.
- R7: A completed word adds one to the winning channel's address and removes one from its count. No other channel's address or count changes.
- R8: When a channel's count goes from 1 to 0, its `done` bit is set and the channel stops contributing to `bus_req` and arbitration, even with `dreq` still high.
- R9: A CPU write (`cfg_we`) loads the selected channel's address, count and enable, and clears its `done` bit.
- R10: Arbitration runs again after every word: a more urgent request wins the next word, and the interrupted channel later resumes at its saved address.
- R11: A channel written with `cfg_en` = 0 is ignored by `bus_req` and arbitration, whatever its `dreq` and count are.
- R12: Dropping `dreq` or raising another request while a word is outstanding does not cancel or change that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | CPU write strobe for one channel's settings |
| cfg_chan | input | CHW | Channel addressed by the write |
| cfg_addr | input | AW | Start address to load |
| cfg_count | input | CW | Number of words to load |
| cfg_en | input | 1 | Enable flag to load |
| dreq | input | NCH | Per-channel peripheral request |
| dack | output | NCH | Per-channel acknowledge, at most one high |
| bus_req | output | 1 | Request for the shared buses to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| xfer_valid | output | 1 | A word transfer is offered to the sequencer |
| xfer_ready | input | 1 | Sequencer accepts and completes the word |
| xfer_addr | output | AW | Memory address of the offered word |
| xfer_chan | output | CHW | Channel that owns the offered word |
| done | output | NCH | Per-channel terminal-count flag |

## Verification
A corrupted per-channel address or count becomes visible at the ports when that channel next wins. It then shows up as a wrong `xfer_addr`, as an extra or missing word, or as a `done` bit that comes early or late. Blocks that are interrupted and later resumed show whether a word leaked into another channel's registers. An arbiter or latch fault shows up within one cycle of the word's start, as a wrong `xfer_chan`, a wrong `dack` bit, or an address that moves while the sequencer stalls. A bus-request fault is seen within a cycle of a count reaching zero or of a request being disabled.

// File: rtl/dma_sel_pkg.sv
package dma_sel_pkg;
  typedef enum logic {
    SEL_IDLE = 1'b0,
    SEL_BUSY = 1'b1
  } sel_state_t;
endpackage

// File: rtl/dma_sel_regs.sv
module dma_sel_regs #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CHW-1:0]          cfg_chan,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [CW-1:0]           cfg_count,
  input  logic                    cfg_en,
  input  logic                    upd,
  input  logic [CHW-1:0]          upd_chan,
  output logic [NCH-1:0][AW-1:0]  ch_addr,
  output logic [NCH-1:0]          ch_live,
  output logic [NCH-1:0]          ch_done
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt_q;
    logic          en_q;
    logic          wr_hit, up_hit;

    assign wr_hit = cfg_we && (cfg_chan == CHW'(i));
    assign up_hit = upd && (upd_chan == CHW'(i)) && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_addr[i] <= '0;
        cnt_q      <= '0;
        en_q       <= 1'b0;
        ch_done[i] <= 1'b0;
      end else if (wr_hit) begin
        ch_addr[i] <= cfg_addr;
        cnt_q      <= cfg_count;
        en_q       <= cfg_en;
        ch_done[i] <= 1'b0;
      end else if (up_hit) begin
        ch_addr[i] <= ch_addr[i] + AW'(1);
        cnt_q      <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) ch_done[i] <= 1'b1;
      end
    end

    assign ch_live[i] = en_q && (cnt_q != '0);
  end
endmodule

// File: rtl/dma_sel_arb.sv
module dma_sel_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  output logic           any,
  output logic [CHW-1:0] win
);
  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) win = CHW'(i);
    end
    any = |elig;
  end
endmodule

// File: rtl/dma_chan_select.sv
module dma_chan_select
  import dma_sel_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_chan,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_count,
  input  logic           cfg_en,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           xfer_valid,
  input  logic           xfer_ready,
  output logic [AW-1:0]  xfer_addr,
  output logic [CHW-1:0] xfer_chan,
  output logic [NCH-1:0] done
);
  sel_state_t               state_q;
  logic [CHW-1:0]           cur_q;
  logic [AW-1:0]            addr_q;
  logic [NCH-1:0][AW-1:0]   ch_addr;
  logic [NCH-1:0]           ch_live;
  logic [NCH-1:0]           elig;
  logic                     any_elig;
  logic [CHW-1:0]           win;
  logic                     word_done;

  assign elig      = ch_live & dreq;
  assign word_done = (state_q == SEL_BUSY) && xfer_ready;

  dma_sel_regs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_chan (cfg_chan),
    .cfg_addr (cfg_addr),
    .cfg_count(cfg_count),
    .cfg_en   (cfg_en),
    .upd      (word_done),
    .upd_chan (cur_q),
    .ch_addr  (ch_addr),
    .ch_live  (ch_live),
    .ch_done  (done)
  );

  dma_sel_arb #(.NCH(NCH)) u_arb (
    .elig(elig),
    .any (any_elig),
    .win (win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEL_IDLE;
      cur_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        SEL_IDLE: if (bus_gnt && any_elig) begin
          state_q <= SEL_BUSY;
          cur_q   <= win;
          addr_q  <= ch_addr[win];
        end
        SEL_BUSY: if (xfer_ready) state_q <= SEL_IDLE;
        default:  state_q <= SEL_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ack
    assign dack[i] = (state_q == SEL_BUSY) && (cur_q == CHW'(i));
  end

  assign xfer_valid = (state_q == SEL_BUSY);
  assign xfer_addr  = addr_q;
  assign xfer_chan  = cur_q;
  assign bus_req    = any_elig || (state_q == SEL_BUSY);
endmodule

// File: rtl/dma_sel_checker.sv
module dma_sel_checker #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dack,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           xfer_valid,
  input logic           xfer_ready,
  input logic [AW-1:0]  xfer_addr,
  input logic [CHW-1:0] xfer_chan
);
  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  assert_ack_follows_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) == xfer_valid);

  assert_ack_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> dack[xfer_chan]);

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_chan)));

  assert_start_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> $past(bus_gnt));

  assert_gap_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> !xfer_valid);

  assert_bus_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> bus_req);
endmodule

bind dma_chan_select dma_sel_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dack      (dack),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .xfer_valid(xfer_valid),
  .xfer_ready(xfer_ready),
  .xfer_addr (xfer_addr),
  .xfer_chan (xfer_chan)
);

// File: tb/dma_chan_select_bench.sv
module dma_chan_select_bench;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 8;
  localparam int CHW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [CHW-1:0] cfg_chan = '0;
  logic [AW-1:0]  cfg_addr = '0;
  logic [CW-1:0]  cfg_count = '0;
  logic           cfg_en = 1'b0;
  logic [NCH-1:0] dreq = '0;
  logic [NCH-1:0] dack;
  logic           bus_req;
  logic           bus_gnt = 1'b0;
  logic           xfer_valid;
  logic           xfer_ready = 1'b0;
  logic [AW-1:0]  xfer_addr;
  logic [CHW-1:0] xfer_chan;
  logic [NCH-1:0] done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dma_chan_select #(.NCH(NCH), .AW(AW), .CW(CW)) u_dma_chan_select (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_en(cfg_en),
    .dreq(dreq), .dack(dack), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_chan(xfer_chan), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: run hung act=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic prog(int ch, int a, int n, bit e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = CHW'(ch); cfg_addr = AW'(a);
    cfg_count = CW'(n); cfg_en = e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Waits for one word, checks owner and address, optionally stalls and drops dreq, completes it.
  task automatic word(string req, int ch, int a, int stall, bit drop);
    int waited = 0;
    while (!xfer_valid && waited < 30) begin
      @(posedge clk); #1; waited++;
    end
    check_eq(req, "xfer_valid", int'(xfer_valid), 1);
    check_eq(req, "xfer_chan", int'(xfer_chan), ch);
    check_eq(req, "xfer_addr", int'(xfer_addr), a);
    check_eq("R5", "dack", int'(dack), 1 << ch);
    if (drop) dreq = '0;
    for (int s = 0; s < stall; s++) begin
      @(posedge clk); #1;
      check_eq("R6", "stalled addr", int'(xfer_addr), a);
      check_eq("R12", "stalled chan", int'(xfer_chan), ch);
    end
    @(negedge clk); xfer_ready = 1'b1;
    @(posedge clk); #1; xfer_ready = 1'b0;
    check_eq("R3", "valid after word", int'(xfer_valid), 0);
    check_eq("R5", "dack after word", int'(dack), 0);
  endtask

  task automatic t_reset;
    check_eq("R1", "dack", int'(dack), 0);
    check_eq("R1", "done", int'(done), 0);
    check_eq("R1", "xfer_valid", int'(xfer_valid), 0);
    check_eq("R1", "bus_req", int'(bus_req), 0);
    dreq = '1;
    @(posedge clk); #1;
    check_eq("R1", "bus_req with zero counts", int'(bus_req), 0);
    dreq = '0;
  endtask

  task automatic t_basic_block;
    bus_gnt = 1'b0;
    prog(2, 'h100, 3, 1'b1);
    dreq = 4'b0100;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check_eq("R2", "bus_req pending", int'(bus_req), 1);
      check_eq("R3", "no word without grant", int'(xfer_valid), 0);
    end
    bus_gnt = 1'b1;
    word("R7", 2, 'h100, 0, 1'b0);
    word("R7", 2, 'h101, 0, 1'b0);
    word("R7", 2, 'h102, 0, 1'b0);
    check_eq("R8", "done after last word", int'(done), 4'b0100);
    check_eq("R8", "bus_req after terminal count", int'(bus_req), 0);
    @(posedge clk); #1;
    check_eq("R8", "no word after terminal count", int'(xfer_valid), 0);
    dreq = '0;
  endtask

  task automatic t_preempt;
    dreq = 4'b1000;
    prog(3, 'h400, 4, 1'b1);
    prog(0, 'h500, 1, 1'b1);
    dreq = 4'b1001;
    word("R12", 3, 'h400, 2, 1'b0);
    word("R10", 0, 'h500, 0, 1'b0);
    dreq = 4'b1000;
    word("R10", 3, 'h401, 0, 1'b0);
    dreq = '0;
    check_eq("R8", "done ch0", int'(done[0]), 1);
    @(posedge clk); #1;
    check_eq("R2", "bus_req without requests", int'(bus_req), 0);
  endtask

  task automatic t_priority;
    prog(1, 'h200, 2, 1'b1);
    dreq = 4'b1010;
    word("R4", 1, 'h200, 0, 1'b0);
    word("R4", 1, 'h201, 0, 1'b0);
    word("R7", 3, 'h402, 0, 1'b0);
    word("R7", 3, 'h403, 0, 1'b0);
    check_eq("R8", "done ch1 ch3", int'(done & 4'b1010), 4'b1010);
    check_eq("R8", "bus_req drained", int'(bus_req), 0);
    dreq = '0;
  endtask

  task automatic t_disabled;
    prog(1, 'h600, 2, 1'b0);
    check_eq("R9", "done ch1 cleared", int'(done[1]), 0);
    dreq = 4'b0010;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check_eq("R11", "bus_req disabled", int'(bus_req), 0);
      check_eq("R11", "valid disabled", int'(xfer_valid), 0);
    end
    prog(1, 'h600, 1, 1'b1);
    word("R11", 1, 'h600, 0, 1'b0);
    dreq = '0;
  endtask

  task automatic t_reload_drop;
    prog(2, 'h700, 2, 1'b1);
    check_eq("R9", "done ch2 cleared", int'(done[2]), 0);
    dreq = 4'b0100;
    word("R12", 2, 'h700, 3, 1'b1);
    check_eq("R12", "bus_req after drop", int'(bus_req), 0);
    dreq = 4'b0100;
    word("R9", 2, 'h701, 0, 1'b0);
    check_eq("R9", "done ch2 after reload", int'(done[2]), 1);
    dreq = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_basic_block;
    t_preempt;
    t_priority;
    t_disabled;
    t_reload_drop;
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule